// File: doc/BRIEF.md
# Multi-Page-Size Fully Associative Translation Buffer

This block translates effective addresses to physical addresses for a memory management unit whose table walk runs in software. It holds a fixed number of translation slots, and every slot is compared against each lookup in parallel. A slot records:

- its own page size,
- an address-space tag,
- a physical page number,
- a protection-group number,
- two cache attributes: cache-inhibit and write-through versus copy-back.

A lookup presents a 32-bit effective address, a 4-bit address-space tag and a load/store flag. One cycle later the block reports hit, miss or fault. On a hit it also reports the translated physical address and the page attributes. A miss is only flagged. The refill handler then writes a slot through the software port at an index it chooses, and it can use three scratch words held in the block.

The result is driven by a four-state outcome machine:

- **RS_IDLE**: no lookup was presented in the previous cycle.
- **RS_HIT**: a permitted translation was found.
- **RS_MISS**: no slot matched.
- **RS_FAULT**: the matching slot's protection group forbids the access.

On every clock edge the machine moves from whatever state it is in:

- to RS_IDLE when no request is present;
- otherwise to RS_MISS when no slot matches;
- otherwise to RS_FAULT when access is denied;
- otherwise to RS_HIT.

Top module: `tlb_mmu`

## Requirements
- R1: After reset every slot is invalid, all result outputs are low, all protection groups grant read-write (code 2), and all scratch words read zero.
- R2: A lookup sampled on a clock edge produces exactly one of rs_hit, rs_miss, rs_fault on the outputs registered at that edge. A cycle without a lookup leaves all three low.
- R3: A slot matches only if all three of these hold:
  - it is valid;
  - its address-space tag equals lk_asid;
  - its stored page number equals lk_ea[31:12] on every bit not masked by its page size.
- R4: Page-size codes are 0 = 4 KB (no bits masked), 1 = 16 KB (page-number bits 1:0 masked), 2 = 256 KB (bits 5:0), 3 = 512 KB (bits 6:0), 4 = 8 MB (bits 10:0). Codes 5 to 7 behave as 4 KB. On a hit, rs_pa takes the masked page-number bits and lk_ea[11:0] from the effective address, and the remaining bits from the stored physical page.
- R5: On a hit, rs_attr_vld is 1 and rs_ci and rs_wt show the slot's cache-inhibit and write-through bits.
- R6: The permission code of the matching slot's protection group decides access:
  - 0 denies everything;
  - 1 allows loads only (lk_write = 0);
  - 2 and 3 allow loads and stores.
  
  Operation 3 sets group sw_group to sw_perm.
- R7: On a fault, rs_pa, rs_ci, rs_wt and rs_attr_vld are all 0.
- R8: When more than one slot matches, rs_multi is raised and the lowest-index matching slot supplies the result. With a single match or a miss, rs_multi is 0.
- R9: Operation 0 loads slot sw_index with the sw_* fields and marks it valid. Operation 1 invalidates slot sw_index only. Operation codes 5 to 7 change nothing.
- R10: Operation 2 clears every valid bit in one cycle, so a lookup on the next edge misses.
- R11: Operation 4 writes sw_word into scratch word sw_index[1:0] for words 0 to 2. Index 3 is ignored. scr_rdata returns the selected word, and returns zero for select 3.
- R12: A lookup on the same edge as a software write sees the table contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address |
| lk_asid | input | 4 | Address-space tag of the access |
| lk_write | input | 1 | 1 = store, 0 = load |
| sw_valid | input | 1 | Software operation strobe |
| sw_op | input | 3 | 0 load, 1 invalidate, 2 invalidate all, 3 set group, 4 scratch write |
| sw_index | input | 5 | Slot index, or scratch index in bits 1:0 |
| sw_epn | input | 20 | Effective page number to store |
| sw_asid | input | 4 | Address-space tag to store |
| sw_size | input | 3 | Page-size code to store |
| sw_rpn | input | 20 | Physical page number to store |
| sw_group | input | 3 | Protection group of the slot, or group to set |
| sw_ci | input | 1 | Cache-inhibit bit to store |
| sw_wt | input | 1 | Write-through bit to store |
| sw_perm | input | 2 | Permission code for operation 3 |
| sw_word | input | 32 | Scratch data |
| scr_sel | input | 2 | Scratch read select |
| scr_rdata | output | 32 | Selected scratch word |
| rs_hit | output | 1 | Permitted translation found |
| rs_miss | output | 1 | No slot matched |
| rs_fault | output | 1 | Access denied by protection group |
| rs_multi | output | 1 | More than one slot matched |
| rs_attr_vld | output | 1 | Attributes and address valid |
| rs_ci | output | 1 | Cache-inhibit attribute |
| rs_wt | output | 1 | Write-through attribute (0 = copy-back) |
| rs_pa | output | 32 | Physical address |

## Verification
The embedded properties check the following on every cycle:

- exactly one outcome per request and silence without one;
- a blank result on a fault;
- pass-through of the page offset on hits;
- rs_multi appearing only with a match;
- slots clearing after an invalidate;
- a miss right after invalidate-all;
- group permissions taking the written value.

Only the bench scenarios can show the following, because they need a reference model of the whole table:

- the size masking at each boundary bit;
- tag separation across all sixteen address spaces;
- the lowest-index choice on multiple matches;
- the permission matrix;
- the old-contents view on a simultaneous write and lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int EA_W     = 32;
    localparam int OFS_W    = 12;
    localparam int VPN_W    = EA_W - OFS_W;
    localparam int ASID_W   = 4;
    localparam int GRP_W    = 3;
    localparam int NGRP     = 1 << GRP_W;
    localparam int SZ_W     = 3;
    localparam int PERM_W   = 2;
    localparam int OP_W     = 3;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD    = 3'd0,
        OP_INVAL   = 3'd1,
        OP_INVALL  = 3'd2,
        OP_GROUP   = 3'd3,
        OP_SCRATCH = 3'd4
    } sw_op_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HIT,
        RS_MISS,
        RS_FAULT
    } res_state_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [SZ_W-1:0]   size;
        logic [VPN_W-1:0]  rpn;
        logic [GRP_W-1:0]  grp;
        logic              ci;
        logic              wt;
    } tlb_entry_t;

    // Page-number bits that the page size turns into offset bits.
    function automatic logic [VPN_W-1:0] size_mask(input logic [SZ_W-1:0] sz);
        logic [VPN_W-1:0] m;
        unique case (sz)
            3'd1:    m = VPN_W'(20'h00003);
            3'd2:    m = VPN_W'(20'h0003F);
            3'd3:    m = VPN_W'(20'h0007F);
            3'd4:    m = VPN_W'(20'h007FF);
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              kill,
    input  tlb_entry_t        wdata,
    input  logic [VPN_W-1:0]  q_vpn,
    input  logic [ASID_W-1:0] q_asid,
    output logic              match,
    output tlb_entry_t        ent
);
    logic             vld;
    logic [VPN_W-1:0] care;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            ent <= '0;
        end else if (kill) begin
            vld <= 1'b0;
        end else if (load) begin
            vld <= 1'b1;
            ent <= wdata;
        end
    end

    always_comb begin
        care  = ~size_mask(ent.size);
        match = vld && (ent.asid == q_asid) && (((ent.vpn ^ q_vpn) & care) == '0);
    end

    // R9 / R10: a killed slot no longer matches anything
    assert_slot_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !match);
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     m,
    output logic             any,
    output logic             multi,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any   = 1'b0;
        multi = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                if (any) multi = 1'b1;
                else     idx   = IDX_W'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_ctlregs.sv
module tlb_ctlregs
    import tlb_pkg::*;
#(
    parameter int SCR_N = 3,
    parameter int SEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_we,
    input  logic [GRP_W-1:0]  grp_sel,
    input  logic [PERM_W-1:0] grp_perm,
    input  logic              scr_we,
    input  logic [SEL_W-1:0]  scr_wsel,
    input  logic [EA_W-1:0]   scr_wdata,
    input  logic [SEL_W-1:0]  scr_rsel,
    output logic [EA_W-1:0]   scr_rdata,
    input  logic [GRP_W-1:0]  q_grp,
    output logic [PERM_W-1:0] q_perm
);
    logic [PERM_W-1:0] perm_q [NGRP];
    logic [EA_W-1:0]   scr_q  [SCR_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NGRP; g++) perm_q[g] <= PERM_W'(2);
        end else if (grp_we) begin
            perm_q[grp_sel] <= grp_perm;
        end
    end

    for (genvar s = 0; s < SCR_N; s++) begin : g_scr
        always_ff @(posedge clk) begin
            if (!rst_n)                               scr_q[s] <= '0;
            else if (scr_we && scr_wsel == SEL_W'(s)) scr_q[s] <= scr_wdata;
        end
    end

    always_comb begin
        scr_rdata = '0;
        for (int s = 0; s < SCR_N; s++)
            if (scr_rsel == SEL_W'(s)) scr_rdata = scr_q[s];
        q_perm = perm_q[q_grp];
    end

    assert_perm_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grp_we |=> perm_q[$past(grp_sel)] == $past(grp_perm));
endmodule

// File: rtl/tlb_mmu.sv
module tlb_mmu
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int SCR_N   = 3,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [EA_W-1:0]   lk_ea,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    input  logic              sw_valid,
    input  logic [OP_W-1:0]   sw_op,
    input  logic [IDX_W-1:0]  sw_index,
    input  logic [VPN_W-1:0]  sw_epn,
    input  logic [ASID_W-1:0] sw_asid,
    input  logic [SZ_W-1:0]   sw_size,
    input  logic [VPN_W-1:0]  sw_rpn,
    input  logic [GRP_W-1:0]  sw_group,
    input  logic              sw_ci,
    input  logic              sw_wt,
    input  logic [PERM_W-1:0] sw_perm,
    input  logic [EA_W-1:0]   sw_word,
    input  logic [SEL_W-1:0]  scr_sel,
    output logic [EA_W-1:0]   scr_rdata,
    output logic              rs_hit,
    output logic              rs_miss,
    output logic              rs_fault,
    output logic              rs_multi,
    output logic              rs_attr_vld,
    output logic              rs_ci,
    output logic              rs_wt,
    output logic [EA_W-1:0]   rs_pa
);
    sw_op_e           op;
    logic             do_load, do_inval, do_invall, do_group, do_scr;
    tlb_entry_t       wdata;
    logic [VPN_W-1:0] q_vpn;
    logic [ENTRIES-1:0] hits;
    tlb_entry_t       ents [ENTRIES];
    logic             any, multi;
    logic [IDX_W-1:0] sel_idx;
    tlb_entry_t       sel;
    logic [PERM_W-1:0] perm;
    logic             allowed;
    logic [VPN_W-1:0] m;
    logic [EA_W-1:0]  pa_c;
    res_state_e       state, state_nx;

    // ---------------- software port decode ----------------
    always_comb begin
        op        = sw_op_e'(sw_op);
        do_load   = sw_valid && (op == OP_LOAD);
        do_inval  = sw_valid && (op == OP_INVAL);
        do_invall = sw_valid && (op == OP_INVALL);
        do_group  = sw_valid && (op == OP_GROUP);
        do_scr    = sw_valid && (op == OP_SCRATCH);
        wdata     = '{vpn: sw_epn, asid: sw_asid, size: sw_size, rpn: sw_rpn,
                      grp: sw_group, ci: sw_ci, wt: sw_wt};
        q_vpn     = lk_ea[EA_W-1:OFS_W];
    end

    // ---------------- slot array ----------------
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        tlb_slot u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (do_load && sw_index == IDX_W'(i)),
            .kill   (do_invall || (do_inval && sw_index == IDX_W'(i))),
            .wdata  (wdata),
            .q_vpn  (q_vpn),
            .q_asid (lk_asid),
            .match  (hits[i]),
            .ent    (ents[i])
        );
    end

    tlb_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .m     (hits),
        .any   (any),
        .multi (multi),
        .idx   (sel_idx)
    );

    tlb_ctlregs #(.SCR_N(SCR_N), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_we    (do_group),
        .grp_sel   (sw_group),
        .grp_perm  (sw_perm),
        .scr_we    (do_scr),
        .scr_wsel  (sw_index[SEL_W-1:0]),
        .scr_wdata (sw_word),
        .scr_rsel  (scr_sel),
        .scr_rdata (scr_rdata),
        .q_grp     (sel.grp),
        .q_perm    (perm)
    );

    // ---------------- translation and next outcome ----------------
    always_comb begin
        sel     = ents[sel_idx];
        allowed = (perm >= PERM_W'(2)) || (perm == PERM_W'(1) && !lk_write);
        m       = size_mask(sel.size);
        pa_c    = {(sel.rpn & ~m) | (q_vpn & m), lk_ea[OFS_W-1:0]};
        if (!lk_valid)    state_nx = RS_IDLE;
        else if (!any)    state_nx = RS_MISS;
        else if (!allowed) state_nx = RS_FAULT;
        else              state_nx = RS_HIT;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_multi    <= 1'b0;
            rs_attr_vld <= 1'b0;
            rs_ci       <= 1'b0;
            rs_wt       <= 1'b0;
            rs_pa       <= '0;
        end else begin
            unique case (state_nx)
                RS_HIT: begin
                    rs_multi    <= multi;
                    rs_attr_vld <= 1'b1;
                    rs_ci       <= sel.ci;
                    rs_wt       <= sel.wt;
                    rs_pa       <= pa_c;
                end
                RS_FAULT: begin
                    rs_multi    <= multi;
                    rs_attr_vld <= 1'b0;
                    rs_ci       <= 1'b0;
                    rs_wt       <= 1'b0;
                    rs_pa       <= '0;
                end
                default: begin
                    rs_multi    <= 1'b0;
                    rs_attr_vld <= 1'b0;
                    rs_ci       <= 1'b0;
                    rs_wt       <= 1'b0;
                    rs_pa       <= '0;
                end
            endcase
        end
    end

    always_comb begin
        rs_hit   = (state == RS_HIT);
        rs_miss  = (state == RS_MISS);
        rs_fault = (state == RS_FAULT);
    end

    // ---------------- assertions ----------------
    assert_single_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rs_hit, rs_miss, rs_fault}));
    assert_answer_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rs_hit || rs_miss || rs_fault));
    assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !(rs_hit || rs_miss || rs_fault));
    assert_fault_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rs_fault |-> (!rs_attr_vld && !rs_ci && !rs_wt && rs_pa == '0));
    assert_offset_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rs_hit || rs_pa[OFS_W-1:0] == $past(lk_ea[OFS_W-1:0])));
    assert_multi_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rs_multi |-> (rs_hit || rs_fault));
    assert_flush_then_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(sw_valid && sw_op == OP_INVALL)) |=> rs_miss);
endmodule

// File: tb/tlb_mmu_tb.sv
module tlb_mmu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [3:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        sw_valid = 1'b0;
    logic [2:0]  sw_op = '0;
    logic [4:0]  sw_index = '0;
    logic [19:0] sw_epn = '0;
    logic [3:0]  sw_asid = '0;
    logic [2:0]  sw_size = '0;
    logic [19:0] sw_rpn = '0;
    logic [2:0]  sw_group = '0;
    logic        sw_ci = 1'b0;
    logic        sw_wt = 1'b0;
    logic [1:0]  sw_perm = '0;
    logic [31:0] sw_word = '0;
    logic [1:0]  scr_sel = '0;
    logic [31:0] scr_rdata;
    logic        rs_hit, rs_miss, rs_fault, rs_multi, rs_attr_vld, rs_ci, rs_wt;
    logic [31:0] rs_pa;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // shadow table
    bit         sv   [32];
    logic [19:0] sepn[32];
    logic [3:0]  sas [32];
    logic [2:0]  ssz [32];
    logic [19:0] srpn[32];
    logic [2:0]  sgrp[32];
    bit         sci  [32];
    bit         swt  [32];
    logic [1:0]  sperm[8];
    logic [31:0] sscr [3];

    always #2 clk = ~clk;   // 250 MHz

    tlb_mmu dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_asid(lk_asid),
        .lk_write(lk_write), .sw_valid(sw_valid), .sw_op(sw_op), .sw_index(sw_index),
        .sw_epn(sw_epn), .sw_asid(sw_asid), .sw_size(sw_size), .sw_rpn(sw_rpn),
        .sw_group(sw_group), .sw_ci(sw_ci), .sw_wt(sw_wt), .sw_perm(sw_perm),
        .sw_word(sw_word), .scr_sel(scr_sel), .scr_rdata(scr_rdata), .rs_hit(rs_hit),
        .rs_miss(rs_miss), .rs_fault(rs_fault), .rs_multi(rs_multi),
        .rs_attr_vld(rs_attr_vld), .rs_ci(rs_ci), .rs_wt(rs_wt), .rs_pa(rs_pa)
    );

    function automatic logic [19:0] mask_of(input logic [2:0] sz);
        case (sz)
            3'd1: return 20'h00003;
            3'd2: return 20'h0003F;
            3'd3: return 20'h0007F;
            3'd4: return 20'h007FF;
            default: return 20'h0;
        endcase
    endfunction

    // expected {hit,miss,fault,multi,attr_vld,ci,wt,pa}
    function automatic logic [38:0] predict(input logic [31:0] ea, input logic [3:0] as, input bit wr);
        int first = -1;
        int n = 0;
        logic [19:0] mk;
        logic [1:0] p;
        bit ok;
        for (int i = 0; i < 32; i++) begin
            mk = mask_of(ssz[i]);
            if (sv[i] && sas[i] == as && ((sepn[i] ^ ea[31:12]) & ~mk) == 20'h0) begin
                n++;
                if (first < 0) first = i;
            end
        end
        if (first < 0) return {7'b0100000, 32'h0};
        mk = mask_of(ssz[first]);
        p  = sperm[sgrp[first]];
        ok = (p >= 2'd2) || (p == 2'd1 && !wr);
        if (!ok) return {3'b001, (n > 1), 3'b000, 32'h0};
        return {3'b100, (n > 1), 1'b1, sci[first], swt[first],
                (srpn[first] & ~mk) | (ea[31:12] & mk), ea[11:0]};
    endfunction

    function automatic logic [38:0] actual();
        return {rs_hit, rs_miss, rs_fault, rs_multi, rs_attr_vld, rs_ci, rs_wt, rs_pa};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic lookup(input string tag, input logic [31:0] ea, input logic [3:0] as, input bit wr);
        logic [38:0] e;
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea; lk_asid = as; lk_write = wr;
        e = predict(ea, as, wr);
        @(negedge clk);
        lk_valid = 1'b0;
        check(tag, 64'(actual()), 64'(e));
    endtask

    task automatic sw_set(input logic [2:0] op, input logic [4:0] idx, input logic [19:0] epn,
                          input logic [3:0] as, input logic [2:0] sz, input logic [19:0] rpn,
                          input logic [2:0] grp, input bit ci, input bit wt,
                          input logic [1:0] perm, input logic [31:0] word);
        sw_valid = 1'b1; sw_op = op; sw_index = idx; sw_epn = epn; sw_asid = as;
        sw_size = sz; sw_rpn = rpn; sw_group = grp; sw_ci = ci; sw_wt = wt;
        sw_perm = perm; sw_word = word;
        case (op)
            3'd0: begin sv[idx] = 1; sepn[idx] = epn; sas[idx] = as; ssz[idx] = sz;
                        srpn[idx] = rpn; sgrp[idx] = grp; sci[idx] = ci; swt[idx] = wt; end
            3'd1: sv[idx] = 0;
            3'd2: for (int i = 0; i < 32; i++) sv[i] = 0;
            3'd3: sperm[grp] = perm;
            3'd4: if (idx[1:0] != 2'd3) sscr[idx[1:0]] = word;
            default: ;
        endcase
    endtask

    task automatic sw(input logic [2:0] op, input logic [4:0] idx, input logic [19:0] epn,
                      input logic [3:0] as, input logic [2:0] sz, input logic [19:0] rpn,
                      input logic [2:0] grp, input bit ci, input bit wt,
                      input logic [1:0] perm, input logic [31:0] word);
        @(negedge clk);
        sw_set(op, idx, epn, as, sz, rpn, grp, ci, wt, perm, word);
        @(negedge clk);
        sw_valid = 1'b0;
    endtask

    task automatic load(input logic [4:0] idx, input logic [19:0] epn, input logic [3:0] as,
                        input logic [2:0] sz, input logic [19:0] rpn, input logic [2:0] grp,
                        input bit ci, input bit wt);
        sw(3'd0, idx, epn, as, sz, rpn, grp, ci, wt, 2'd0, 32'h0);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [38:0] e;
        for (int i = 0; i < 32; i++) sv[i] = 0;
        for (int g = 0; g < 8; g++) sperm[g] = 2'd2;
        for (int s = 0; s < 3; s++) sscr[s] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 outputs", 64'(actual()), 64'h0);
        for (int s = 0; s < 4; s++) begin
            scr_sel = 2'(s); #1;
            check("R1 scratch", 64'(scr_rdata), 64'h0);
        end
        lookup("R1 empty miss", 32'h1234_5678, 4'd0, 1'b0);
        for (int g = 0; g < 8; g++) begin
            load(5'd31, 20'hF0F00 + 20'(g), 4'd1, 3'd0, 20'h0AAAA, 3'(g), 1'b0, 1'b0);
            lookup("R1 group default rw", {20'hF0F00 + 20'(g), 12'h010}, 4'd1, 1'b1);
        end
        sw(3'd2, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);

        // R3 R4 R5: size sweep with one-bit perturbation of the page number
        for (int sz = 0; sz < 8; sz++) begin
            sw(3'd2, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
            load(5'(sz * 3), 20'hABCDE, 4'd5, 3'(sz), 20'h13579, 3'd0, sz[0], sz[1]);
            lookup("R4 size exact", 32'hABCDE_9A5, 4'd5, 1'b0);
            lookup("R3 asid mismatch", 32'hABCDE_9A5, 4'd6, 1'b0);
            for (int b = 0; b < 20; b++)
                lookup("R4 size boundary bit", {20'hABCDE ^ (20'h1 << b), 12'h3C7}, 4'd5, 1'b0);
        end

        // R3: all address spaces share one page number
        sw(3'd2, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        for (int a = 0; a < 16; a++)
            load(5'(a), 20'h55555, 4'(a), 3'(a % 5), 20'(a * 16'h111), 3'd0, a[0], a[2]);
        for (int a = 0; a < 16; a++) begin
            lookup("R3 asid sweep", {20'h55555, 12'(a * 7)}, 4'(a), 1'b0);
            lookup("R3 wrong page", {20'h55554 ^ 20'h80000, 12'h0}, 4'(a), 1'b0);
        end

        // R6 R7: permission matrix, group g gets code (p+g)%4
        sw(3'd2, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        for (int g = 0; g < 8; g++)
            load(5'(g + 8), 20'h30000 + 20'(g << 8), 4'd2, 3'd1, 20'h70000 + 20'(g), 3'(g), 1'b1, 1'b1);
        for (int p = 0; p < 4; p++) begin
            for (int g = 0; g < 8; g++)
                sw(3'd3, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'(g), 1'b0, 1'b0, 2'((p + g) % 4), 32'h0);
            for (int g = 0; g < 8; g++) begin
                lookup("R6 load access", {20'h30000 + 20'(g << 8) + 20'd2, 12'h111}, 4'd2, 1'b0);
                lookup("R7 store access", {20'h30000 + 20'(g << 8) + 20'd1, 12'h222}, 4'd2, 1'b1);
            end
        end
        for (int g = 0; g < 8; g++)
            sw(3'd3, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'(g), 1'b0, 1'b0, 2'd2, 32'h0);

        // R8: multiple matches, lowest index wins
        sw(3'd2, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        load(5'd20, 20'h40000, 4'd3, 3'd4, 20'h22200, 3'd0, 1'b1, 1'b0);
        load(5'd7,  20'h40012, 4'd3, 3'd0, 20'h99999, 3'd0, 1'b0, 1'b1);
        lookup("R8 double match", 32'h40012_abc, 4'd3, 1'b0);
        check("R8 lowest index pa", 64'(rs_pa), 64'h99999abc);
        lookup("R8 single match", 32'h40013_abc, 4'd3, 1'b0);
        load(5'd3, 20'h40010, 4'd3, 3'd1, 20'h11110, 3'd0, 1'b1, 1'b1);
        lookup("R8 triple match", 32'h40012_001, 4'd3, 1'b0);
        sw(3'd3, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        lookup("R8 multi on fault", 32'h40012_001, 4'd3, 1'b0);
        sw(3'd3, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd2, 32'h0);

        // R9: single invalidate and ignored opcodes
        sw(3'd1, 5'd3, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        lookup("R9 invalidate one", 32'h40012_001, 4'd3, 1'b0);
        sw(3'd1, 5'd7, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        lookup("R9 fallback to next", 32'h40012_001, 4'd3, 1'b0);
        for (int o = 5; o < 8; o++) begin
            sw(3'(o), 5'd20, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'hDEAD0000);
            lookup("R9 unused opcode", 32'h407FF_fff, 4'd3, 1'b0);
        end

        // R10: invalidate all then immediate lookup
        @(negedge clk);
        sw_set(3'd2, 5'd0, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        @(negedge clk);
        sw_valid = 1'b0;
        lk_valid = 1'b1; lk_ea = 32'h40000_000; lk_asid = 4'd3; lk_write = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0;
        check("R10 flush next cycle", 64'(actual()), 64'(predict(32'h40000_000, 4'd3, 1'b0)));

        // R12: write and lookup on the same edge
        load(5'd9, 20'h66666, 4'd4, 3'd0, 20'h12345, 3'd0, 1'b0, 1'b0);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = 32'h66666_010; lk_asid = 4'd4; lk_write = 1'b0;
        e = predict(32'h66666_010, 4'd4, 1'b0);
        sw_set(3'd0, 5'd9, 20'h66666, 4'd4, 3'd0, 20'h54321, 3'd0, 1'b1, 1'b1, 2'd0, 32'h0);
        @(negedge clk);
        lk_valid = 1'b0; sw_valid = 1'b0;
        check("R12 old contents", 64'(actual()), 64'(e));
        lookup("R12 new contents", 32'h66666_010, 4'd4, 1'b0);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = 32'h66666_020; lk_asid = 4'd4;
        e = predict(32'h66666_020, 4'd4, 1'b0);
        sw_set(3'd1, 5'd9, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'h0);
        @(negedge clk);
        lk_valid = 1'b0; sw_valid = 1'b0;
        check("R12 hit before invalidate", 64'(actual()), 64'(e));
        @(negedge clk);
        check("R2 idle without request", 64'(actual()), 64'h0);

        // R11: scratch words
        for (int s = 0; s < 4; s++)
            sw(3'd4, 5'(s), 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'hC0DE0000 + 32'(s));
        sw(3'd4, 5'd5, 20'h0, 4'd0, 3'd0, 20'h0, 3'd0, 1'b0, 1'b0, 2'd0, 32'hBEEF0001);
        for (int s = 0; s < 4; s++) begin
            scr_sel = 2'(s); #1;
            check("R11 scratch read", 64'(scr_rdata), (s == 3) ? 64'h0 : 64'(sscr[s]));
        end

        summary();
    end
endmodule